// File: doc/BRIEF.md
# Cascaded Interrupt Controller Pair with Acknowledge Sequencer

This block joins two eight-line priority interrupt controllers into a single sixteen-line source. The upper controller (the primary) drives the CPU interrupt request. The lower controller (the secondary) feeds its requests into primary line 2. The CPU configures and inspects both controllers over a byte-wide port bus. When it takes an interrupt, it pulses an acknowledge strobe. One cycle later the block returns the 8-bit vector and the 4-bit system line that was serviced. In the same cycle as the strobe, it updates the in-service, pending and rotation state of each controller.

Each controller holds a pending register, a mask register, an in-service register, a per-line trigger-mode register and a 3-bit rotation offset. Priority is counted from the line just after the offset. A small configuration FSM takes the set-up words.

The FSM has four states. `CFG_READY` is the normal state, in which data-port writes load the mask. `CFG_BASE` waits for the vector-base word. `CFG_CASCADE` waits for the cascade word. `CFG_MODE` waits for the optional mode word.

The transitions are:
- An initialise command moves any state to `CFG_BASE`.
- A data write moves `CFG_BASE` to `CFG_CASCADE`.
- A data write moves `CFG_CASCADE` to `CFG_MODE` when the initialise command asked for a mode word, and to `CFG_READY` otherwise.
- A data write moves `CFG_MODE` to `CFG_READY`.

Top module: `pic_cascade_ack`

## Requirements
- R1: After reset, every pending, mask, in-service and trigger-mode register reads 0, the rotation offset is 0, `int_o` and `vec_vld_o` are 0, and both FSMs are in `CFG_READY`.
- R2: The trigger mode of a line is set by its bit in that controller's trigger register. The writable bits are 0xF8 on the primary and 0xDE on the secondary; other bits read 0.
  - A 0 (edge) line becomes pending on a 0-to-1 transition and stays pending while the input is held. It is not re-armed until the input has dropped.
  - A 1 (level) line's pending bit follows the input with one cycle of latency.
- R3: On each controller the candidate is the unmasked pending line that comes first in the order offset, offset+1, ... (mod 8). It wins only if it ranks strictly before every in-service line in that same order.
- R4: On an acknowledge with a primary winner other than line 2, the vector is base + line and the system line is that line. The in-service bit of that line is set, and its pending bit is cleared only when the line is edge triggered. The result, with `vec_vld_o`, appears in the cycle after the strobe. An acknowledge must never coincide with a bus write.
- R5: While the secondary has a winner and no acknowledge is in progress, primary line 2 is marked pending. When the primary winner is line 2, both controllers' winners are acknowledged. The vector is the secondary base + secondary line, and the system line is secondary line + 8.
- R6: An acknowledge with no primary winner returns the primary base + 7 and system line 7, and changes no state.
- R7: An acknowledge whose primary winner is line 2, while the secondary has no winner, returns the secondary base + 7 and system line 15. The primary line-2 in-service bit is set and the secondary in-service register is unchanged.
- R8: With auto end-of-interrupt selected, an acknowledge leaves the in-service register unchanged. If rotate-on-auto-end is also set, the offset becomes the acknowledged line + 1 (mod 8).
- R9: A command-port write with bits 4 and 3 clear decodes bits 7:5 as follows, with bits 2:0 naming a line:
  - 0 clears rotate-on-auto-end and 4 sets it.
  - 1 clears the highest-priority in-service bit; 5 does the same and sets the offset to that line + 1.
  - 3 clears the named in-service bit; 7 does the same and sets the offset to the named line + 1.
  - 6 sets the offset to the named line + 1.
  - 2 does nothing.
- R10: A command-port write with bit 4 set clears the pending, in-service, mask and offset registers, the base and all mode flags, but not the trigger register. It records bit 0 as "mode word follows" and enters `CFG_BASE`.
  - The next data write loads the base from bits 7:3.
  - The next data write is the cascade word and is discarded.
  - If a mode word follows, the next data write sets nesting mode from bit 4 and auto end-of-interrupt from bit 1.
- R11: In nesting mode on the primary, its line-2 in-service bit is left out of the in-service comparison. A higher-priority secondary request can therefore interrupt while line 2 is in service.
- R12: Port decode works as follows:
  - 0x20 and 0x21 address the primary command and data ports; 0xA0 and 0xA1 address the secondary ones.
  - 0x4D0 and 0x4D1 address the primary and secondary trigger registers.
  - A command-port read returns the pending register, or the in-service register after a command write with bit 3 set, bit 1 set and bit 0 = 1. The same write with bit 0 = 0 selects the pending register again.
  - A data-port read returns the mask.
  - An access whose length is not 1, or whose address matches none of these, writes nothing and reads 0.
- R13: `int_o` is 1 exactly when the primary has a winner. It reflects every register update from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines_i | input | 16 | System interrupt inputs; bit 2 is unused (cascade) |
| bus_wr_i | input | 1 | Port write strobe |
| bus_rd_i | input | 1 | Port read strobe |
| bus_addr_i | input | 16 | Port address |
| bus_len_i | input | 3 | Access length in bytes |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational |
| inta_i | input | 1 | Interrupt acknowledge strobe |
| int_o | output | 1 | Interrupt request to the CPU |
| vec_vld_o | output | 1 | Acknowledge result valid, one cycle after `inta_i` |
| vec_o | output | 8 | Interrupt vector |
| vec_line_o | output | 4 | Acknowledged system line (0..15) |

## Verification
A corrupted pending, in-service or offset register shows at `int_o` in the very next cycle: the wrong winner appears, or a request is blocked. The reference model compares `int_o` on every clock, so such a fault surfaces immediately. A wrong rotation or base shows on the next acknowledge as a wrong `vec_o` or `vec_line_o`. State that never reaches `int_o`, such as the read select or an in-service bit held by auto end-of-interrupt, is brought out by register reads right after the stimulus.

// File: rtl/pic_pkg.sv
package pic_pkg;

    localparam int PIC_W  = 8;
    localparam int IDX_W  = $clog2(PIC_W);
    localparam int RANK_W = IDX_W + 1;

    typedef enum logic [1:0] {
        CFG_READY,
        CFG_BASE,
        CFG_CASCADE,
        CFG_MODE
    } cfg_state_e;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_M_CMD,
        TGT_M_DATA,
        TGT_S_CMD,
        TGT_S_DATA,
        TGT_M_TRIG,
        TGT_S_TRIG
    } bus_tgt_e;

    // Rank of the first set bit of m, counting from position off upward (mod PIC_W).
    // Returns PIC_W when m is empty.
    function automatic logic [RANK_W-1:0] rank_of(input logic [PIC_W-1:0] m,
                                                  input logic [IDX_W-1:0] off);
        logic [RANK_W-1:0] r;
        r = RANK_W'(PIC_W);
        for (int p = PIC_W - 1; p >= 0; p--) begin
            if (m[IDX_W'(p) + off]) r = RANK_W'(p);
        end
        return r;
    endfunction

endpackage

// File: rtl/pic_port_decode.sv
module pic_port_decode
    import pic_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter int              LEN_W     = 3,
    parameter logic [ADDR_W-1:0] M_BASE    = 16'h0020,
    parameter logic [ADDR_W-1:0] S_BASE    = 16'h00A0,
    parameter logic [ADDR_W-1:0] TRIG_BASE = 16'h04D0
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LEN_W-1:0]  len_i,
    output bus_tgt_e          tgt_o
);

    logic byte_ok;
    assign byte_ok = (len_i == LEN_W'(1));

    always_comb begin
        tgt_o = TGT_NONE;
        if (byte_ok) begin
            if (addr_i[ADDR_W-1:1] == M_BASE[ADDR_W-1:1])
                tgt_o = addr_i[0] ? TGT_M_DATA : TGT_M_CMD;
            else if (addr_i[ADDR_W-1:1] == S_BASE[ADDR_W-1:1])
                tgt_o = addr_i[0] ? TGT_S_DATA : TGT_S_CMD;
            else if (addr_i[ADDR_W-1:1] == TRIG_BASE[ADDR_W-1:1])
                tgt_o = addr_i[0] ? TGT_S_TRIG : TGT_M_TRIG;
        end
    end

endmodule

// File: rtl/pic_unit.sv
module pic_unit
    import pic_pkg::*;
#(
    parameter logic [PIC_W-1:0] LVL_ALLOW = 8'hFF,
    parameter logic [PIC_W-1:0] NEST_MASK = 8'h00
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIC_W-1:0] lines_i,
    input  logic [PIC_W-1:0] pulse_i,
    input  logic             cmd_we_i,
    input  logic             data_we_i,
    input  logic             trig_we_i,
    input  logic [7:0]       wdata_i,
    input  logic             ack_i,
    output logic             win_vld_o,
    output logic [IDX_W-1:0] win_line_o,
    output logic [PIC_W-1:0] irr_o,
    output logic [PIC_W-1:0] isr_o,
    output logic [PIC_W-1:0] imr_o,
    output logic [PIC_W-1:0] lvl_o,
    output logic             rsel_o,
    output logic [4:0]       base_o
);

    cfg_state_e state_q, state_n;
    logic [PIC_W-1:0] irr_q, irr_n, isr_q, isr_n, imr_q, imr_n;
    logic [PIC_W-1:0] lvl_q, lvl_n, last_q, last_n;
    logic [IDX_W-1:0] off_q, off_n;
    logic [4:0]       base_q, base_n;
    logic aeoi_q, aeoi_n, rot_q, rot_n, nest_q, nest_n;
    logic init4_q, init4_n, rsel_q, rsel_n;

    // resolver
    logic [RANK_W-1:0] req_rank, cur_rank, eoi_rank;
    logic [IDX_W-1:0]  eoi_line;
    logic [PIC_W-1:0]  ack_bit;

    assign req_rank   = rank_of(irr_q & ~imr_q, off_q);
    assign cur_rank   = rank_of(isr_q & ~(nest_q ? NEST_MASK : '0), off_q);
    assign win_vld_o  = (req_rank < cur_rank);
    assign win_line_o = req_rank[IDX_W-1:0] + off_q;
    assign eoi_rank   = rank_of(isr_q, off_q);
    assign eoi_line   = eoi_rank[IDX_W-1:0] + off_q;
    assign ack_bit    = PIC_W'(1) << win_line_o;

    logic       init_cmd, sel_cmd, ocw_cmd;
    logic [2:0] op;
    assign init_cmd = cmd_we_i && wdata_i[4];
    assign sel_cmd  = cmd_we_i && !wdata_i[4] && wdata_i[3];
    assign ocw_cmd  = cmd_we_i && !wdata_i[4] && !wdata_i[3];
    assign op       = wdata_i[7:5];

    // configuration FSM: state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CFG_READY;
        else        state_q <= state_n;
    end

    always_comb begin
        state_n = state_q;
        if (init_cmd) begin
            state_n = CFG_BASE;
        end else if (data_we_i) begin
            unique case (state_q)
                CFG_READY:   state_n = CFG_READY;
                CFG_BASE:    state_n = CFG_CASCADE;
                CFG_CASCADE: state_n = init4_q ? CFG_MODE : CFG_READY;
                CFG_MODE:    state_n = CFG_READY;
            endcase
        end
    end

    // datapath next-state
    always_comb begin
        isr_n   = isr_q;
        imr_n   = imr_q;
        off_n   = off_q;
        base_n  = base_q;
        aeoi_n  = aeoi_q;
        rot_n   = rot_q;
        nest_n  = nest_q;
        init4_n = init4_q;
        rsel_n  = rsel_q;
        last_n  = lines_i;
        lvl_n   = trig_we_i ? (wdata_i & LVL_ALLOW) : lvl_q;
        irr_n   = (lvl_q & lines_i)
                | (~lvl_q & ((irr_q & ~(ack_i ? ack_bit : '0))
                             | (lines_i & ~last_q) | pulse_i));

        if (ack_i && !aeoi_q) isr_n = isr_q | ack_bit;
        if (ack_i && aeoi_q && rot_q) off_n = win_line_o + IDX_W'(1);

        if (init_cmd) begin
            irr_n   = '0;
            last_n  = '0;
            isr_n   = '0;
            imr_n   = '0;
            off_n   = '0;
            base_n  = '0;
            aeoi_n  = 1'b0;
            rot_n   = 1'b0;
            nest_n  = 1'b0;
            rsel_n  = 1'b0;
            init4_n = wdata_i[0];
        end else if (sel_cmd) begin
            if (wdata_i[1]) rsel_n = wdata_i[0];
        end else if (ocw_cmd) begin
            unique case (op)
                3'd0, 3'd4: rot_n = op[2];
                3'd1, 3'd5: begin
                    if (!eoi_rank[IDX_W]) begin
                        isr_n = isr_q & ~(PIC_W'(1) << eoi_line);
                        if (op[2]) off_n = eoi_line + IDX_W'(1);
                    end
                end
                3'd2: ;
                3'd3: isr_n = isr_q & ~(PIC_W'(1) << wdata_i[IDX_W-1:0]);
                3'd6: off_n = wdata_i[IDX_W-1:0] + IDX_W'(1);
                3'd7: begin
                    isr_n = isr_q & ~(PIC_W'(1) << wdata_i[IDX_W-1:0]);
                    off_n = wdata_i[IDX_W-1:0] + IDX_W'(1);
                end
            endcase
        end

        if (data_we_i) begin
            unique case (state_q)
                CFG_READY:   imr_n = wdata_i;
                CFG_BASE:    base_n = wdata_i[7:3];
                CFG_CASCADE: ;
                CFG_MODE: begin
                    nest_n = wdata_i[4];
                    aeoi_n = wdata_i[1];
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr_q <= '0; isr_q <= '0; imr_q <= '0; lvl_q <= '0; last_q <= '0;
            off_q <= '0; base_q <= '0; aeoi_q <= 1'b0; rot_q <= 1'b0;
            nest_q <= 1'b0; init4_q <= 1'b0; rsel_q <= 1'b0;
        end else begin
            irr_q <= irr_n; isr_q <= isr_n; imr_q <= imr_n; lvl_q <= lvl_n;
            last_q <= last_n; off_q <= off_n; base_q <= base_n;
            aeoi_q <= aeoi_n; rot_q <= rot_n; nest_q <= nest_n;
            init4_q <= init4_n; rsel_q <= rsel_n;
        end
    end

    assign irr_o  = irr_q;
    assign isr_o  = isr_q;
    assign imr_o  = imr_q;
    assign lvl_o  = lvl_q;
    assign rsel_o = rsel_q;
    assign base_o = base_q;

    assert_ack_has_winner_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |-> win_vld_o);
    assert_ack_sets_service_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !aeoi_q) |=> isr_q[$past(win_line_o)]);
    assert_auto_end_keeps_service_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && aeoi_q) |=> (isr_q == $past(isr_q)));

endmodule

// File: rtl/pic_cascade_ack.sv
module pic_cascade_ack
    import pic_pkg::*;
#(
    parameter int                ADDR_W     = 16,
    parameter int                LEN_W      = 3,
    parameter logic [ADDR_W-1:0] M_BASE     = 16'h0020,
    parameter logic [ADDR_W-1:0] S_BASE     = 16'h00A0,
    parameter logic [ADDR_W-1:0] TRIG_BASE  = 16'h04D0,
    parameter logic [PIC_W-1:0]  M_LVL_OK   = 8'hF8,
    parameter logic [PIC_W-1:0]  S_LVL_OK   = 8'hDE,
    parameter int                CASC_IDX   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2*PIC_W-1:0]  irq_lines_i,
    input  logic                bus_wr_i,
    input  logic                bus_rd_i,
    input  logic [ADDR_W-1:0]   bus_addr_i,
    input  logic [LEN_W-1:0]    bus_len_i,
    input  logic [7:0]          bus_wdata_i,
    output logic [7:0]          bus_rdata_o,
    input  logic                inta_i,
    output logic                int_o,
    output logic                vec_vld_o,
    output logic [7:0]          vec_o,
    output logic [IDX_W:0]      vec_line_o
);

    localparam logic [PIC_W-1:0] CASC_BIT = PIC_W'(1) << CASC_IDX;
    localparam logic [IDX_W-1:0] SPUR     = IDX_W'(PIC_W - 1);

    bus_tgt_e tgt;

    pic_port_decode #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W),
        .M_BASE(M_BASE), .S_BASE(S_BASE), .TRIG_BASE(TRIG_BASE)
    ) decode_i (
        .addr_i(bus_addr_i), .len_i(bus_len_i), .tgt_o(tgt)
    );

    logic             m_vld, s_vld, m_ack, s_ack, casc;
    logic [IDX_W-1:0] m_line, s_line;
    logic [PIC_W-1:0] m_irr, m_isr, m_imr, m_lvl, s_irr, s_isr, s_imr, s_lvl;
    logic             m_rsel, s_rsel;
    logic [4:0]       m_base, s_base;

    assign casc  = s_vld && !inta_i;
    assign m_ack = inta_i && m_vld;
    assign s_ack = m_ack && (m_line == IDX_W'(CASC_IDX)) && s_vld;

    pic_unit #(.LVL_ALLOW(M_LVL_OK), .NEST_MASK(CASC_BIT)) master_i (
        .clk(clk), .rst_n(rst_n),
        .lines_i(irq_lines_i[PIC_W-1:0] & ~CASC_BIT),
        .pulse_i(casc ? CASC_BIT : '0),
        .cmd_we_i(bus_wr_i && tgt == TGT_M_CMD),
        .data_we_i(bus_wr_i && tgt == TGT_M_DATA),
        .trig_we_i(bus_wr_i && tgt == TGT_M_TRIG),
        .wdata_i(bus_wdata_i), .ack_i(m_ack),
        .win_vld_o(m_vld), .win_line_o(m_line),
        .irr_o(m_irr), .isr_o(m_isr), .imr_o(m_imr), .lvl_o(m_lvl),
        .rsel_o(m_rsel), .base_o(m_base)
    );

    pic_unit #(.LVL_ALLOW(S_LVL_OK), .NEST_MASK('0)) slave_i (
        .clk(clk), .rst_n(rst_n),
        .lines_i(irq_lines_i[2*PIC_W-1:PIC_W]),
        .pulse_i('0),
        .cmd_we_i(bus_wr_i && tgt == TGT_S_CMD),
        .data_we_i(bus_wr_i && tgt == TGT_S_DATA),
        .trig_we_i(bus_wr_i && tgt == TGT_S_TRIG),
        .wdata_i(bus_wdata_i), .ack_i(s_ack),
        .win_vld_o(s_vld), .win_line_o(s_line),
        .irr_o(s_irr), .isr_o(s_isr), .imr_o(s_imr), .lvl_o(s_lvl),
        .rsel_o(s_rsel), .base_o(s_base)
    );

    // acknowledge result
    logic [7:0]     res_vec;
    logic [IDX_W:0] res_line;

    always_comb begin
        if (!m_vld) begin
            res_vec  = {m_base, SPUR};
            res_line = {1'b0, SPUR};
        end else if (m_line == IDX_W'(CASC_IDX)) begin
            res_vec  = {s_base, s_vld ? s_line : SPUR};
            res_line = {1'b1, s_vld ? s_line : SPUR};
        end else begin
            res_vec  = {m_base, m_line};
            res_line = {1'b0, m_line};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_vld_o  <= 1'b0;
            vec_o      <= '0;
            vec_line_o <= '0;
        end else begin
            vec_vld_o <= inta_i;
            if (inta_i) begin
                vec_o      <= res_vec;
                vec_line_o <= res_line;
            end
        end
    end

    always_comb begin
        bus_rdata_o = '0;
        if (bus_rd_i) begin
            unique case (tgt)
                TGT_M_CMD:  bus_rdata_o = m_rsel ? m_isr : m_irr;
                TGT_M_DATA: bus_rdata_o = m_imr;
                TGT_S_CMD:  bus_rdata_o = s_rsel ? s_isr : s_irr;
                TGT_S_DATA: bus_rdata_o = s_imr;
                TGT_M_TRIG: bus_rdata_o = m_lvl;
                TGT_S_TRIG: bus_rdata_o = s_lvl;
                TGT_NONE:   bus_rdata_o = '0;
                default:    bus_rdata_o = '0;
            endcase
        end
    end

    assign int_o = m_vld;

    assert_no_ack_with_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        inta_i |-> !bus_wr_i);
    assert_spurious_primary_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (inta_i && !m_vld) |=> (vec_vld_o && vec_line_o == {1'b0, SPUR}));
    assert_cascade_marks_line2_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_vld && !inta_i && !(bus_wr_i && tgt == TGT_M_CMD && bus_wdata_i[4]))
        |=> m_irr[CASC_IDX]);

endmodule

// File: tb/pic_cascade_ack_tb.sv
module pic_cascade_ack_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_lines_i = '0;
    logic        bus_wr_i = 1'b0, bus_rd_i = 1'b0, inta_i = 1'b0;
    logic [15:0] bus_addr_i = '0;
    logic [2:0]  bus_len_i = 3'd1;
    logic [7:0]  bus_wdata_i = '0;
    logic [7:0]  bus_rdata_o, vec_o;
    logic        int_o, vec_vld_o;
    logic [3:0]  vec_line_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    pic_cascade_ack dut_i (
        .clk(clk), .rst_n(rst_n), .irq_lines_i(irq_lines_i),
        .bus_wr_i(bus_wr_i), .bus_rd_i(bus_rd_i), .bus_addr_i(bus_addr_i),
        .bus_len_i(bus_len_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
        .inta_i(inta_i), .int_o(int_o), .vec_vld_o(vec_vld_o),
        .vec_o(vec_o), .vec_line_o(vec_line_o)
    );

    int checks = 0, errors = 0;
    string cur = "R1";
    logic [15:0] lines_r = '0;

    // behavioural model: index 0 = primary, 1 = secondary
    int irr[2], isr[2], imr[2], lvl[2], last[2], base[2], off[2];
    int aeoi[2], rot[2], nest[2], rsel[2], stage[2], init4[2];
    int exp_int = 0, exp_vld = 0, exp_vec = 0, exp_line = 0;

    task automatic check(input int act, input int exp, input string tag, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic int prio(input int mask, input int o);
        for (int p = 0; p < 8; p++) if (((mask >> ((p + o) % 8)) & 1) != 0) return p;
        return 8;
    endfunction

    function automatic int winner(input int c);
        int p, cp, m;
        p = prio(irr[c] & ~imr[c] & 255, off[c]);
        if (p == 8) return -1;
        m = isr[c];
        if (c == 0 && nest[0] != 0) m = m & ~4;
        cp = prio(m, off[c]);
        return (p < cp) ? (p + off[c]) % 8 : -1;
    endfunction

    task automatic do_ack(input int c, input int w);
        isr[c] |= (1 << w);
        if (aeoi[c] != 0) begin
            if (rot[c] != 0) off[c] = (w + 1) % 8;
            isr[c] &= ~(1 << w);
        end
        if (((lvl[c] >> w) & 1) == 0) irr[c] &= ~(1 << w);
    endtask

    task automatic model_reset();
        for (int c = 0; c < 2; c++) begin
            irr[c] = 0; isr[c] = 0; imr[c] = 0; lvl[c] = 0; last[c] = 0; base[c] = 0;
            off[c] = 0; aeoi[c] = 0; rot[c] = 0; nest[c] = 0; rsel[c] = 0;
            stage[c] = 0; init4[c] = 0;
        end
    endtask

    task automatic cmd_write(input int c, input int v);
        int cm, p, ln;
        if ((v & 16) != 0) begin
            irr[c] = 0; last[c] = 0; isr[c] = 0; imr[c] = 0; off[c] = 0; base[c] = 0;
            aeoi[c] = 0; rot[c] = 0; nest[c] = 0; rsel[c] = 0;
            stage[c] = 1; init4[c] = v & 1;
        end else if ((v & 8) != 0) begin
            if ((v & 2) != 0) rsel[c] = v & 1;
        end else begin
            cm = v >> 5;
            ln = v & 7;
            case (cm)
                0, 4: rot[c] = cm >> 2;
                1, 5: begin
                    p = prio(isr[c], off[c]);
                    if (p != 8) begin
                        p = (p + off[c]) % 8;
                        isr[c] &= ~(1 << p);
                        if (cm == 5) off[c] = (p + 1) % 8;
                    end
                end
                3: isr[c] &= ~(1 << ln);
                6: off[c] = (ln + 1) % 8;
                7: begin isr[c] &= ~(1 << ln); off[c] = (ln + 1) % 8; end
                default: ;
            endcase
        end
    endtask

    task automatic data_write(input int c, input int v);
        case (stage[c])
            0: imr[c] = v;
            1: begin base[c] = v & 248; stage[c] = 2; end
            2: stage[c] = (init4[c] != 0) ? 3 : 0;
            default: begin nest[c] = (v >> 4) & 1; aeoi[c] = (v >> 1) & 1; stage[c] = 0; end
        endcase
    endtask

    function automatic int model_read(input int a, input int len);
        if (len != 1) return 0;
        case (a)
            'h20:  return (rsel[0] != 0) ? isr[0] : irr[0];
            'h21:  return imr[0];
            'hA0:  return (rsel[1] != 0) ? isr[1] : irr[1];
            'hA1:  return imr[1];
            'h4D0: return lvl[0];
            'h4D1: return lvl[1];
            default: return 0;
        endcase
    endfunction

    task automatic model_step(input int ack, input int wr, input int a, input int len,
                              input int d, input int ln);
        int mw, sw, li[2];
        mw = winner(0);
        sw = winner(1);
        exp_vld = ack;
        if (ack != 0) begin
            if (mw < 0) begin
                exp_vec = base[0] + 7; exp_line = 7;
            end else if (mw == 2) begin
                do_ack(0, 2);
                if (sw >= 0) begin
                    do_ack(1, sw); exp_vec = base[1] + sw; exp_line = sw + 8;
                end else begin
                    exp_vec = base[1] + 7; exp_line = 15;
                end
            end else begin
                do_ack(0, mw); exp_vec = base[0] + mw; exp_line = mw;
            end
        end
        li[0] = ln & 'hFB;
        li[1] = (ln >> 8) & 'hFF;
        for (int c = 0; c < 2; c++) begin
            for (int b = 0; b < 8; b++) begin
                if (((lvl[c] >> b) & 1) != 0) begin
                    if (((li[c] >> b) & 1) != 0) irr[c] |= (1 << b);
                    else irr[c] &= ~(1 << b);
                end else if (((li[c] >> b) & 1) != 0 && ((last[c] >> b) & 1) == 0) begin
                    irr[c] |= (1 << b);
                end
            end
            last[c] = li[c];
        end
        if (sw >= 0 && ack == 0) irr[0] |= 4;
        if (wr != 0 && len == 1) begin
            case (a)
                'h20:  cmd_write(0, d);
                'h21:  data_write(0, d);
                'hA0:  cmd_write(1, d);
                'hA1:  data_write(1, d);
                'h4D0: lvl[0] = d & 'hF8;
                'h4D1: lvl[1] = d & 'hDE;
                default: ;
            endcase
        end
        exp_int = (winner(0) >= 0) ? 1 : 0;
    endtask

    task automatic run_cycle(input logic ack, input logic wr, input logic rd,
                             input int a, input int len, input int d);
        @(negedge clk);
        inta_i = ack; bus_wr_i = wr; bus_rd_i = rd;
        bus_addr_i = 16'(a); bus_len_i = 3'(len); bus_wdata_i = 8'(d);
        irq_lines_i = lines_r;
        #1;
        if (rd) check(int'(bus_rdata_o), model_read(a, len), cur, "read data");
        model_step(int'(ack), int'(wr), a, len, d, int'(lines_r));
        @(posedge clk);
        #1;
        check(int'(int_o), exp_int, "R13", "int_o");
        check(int'(vec_vld_o), exp_vld, cur, "vec_vld_o");
        if (exp_vld != 0) begin
            check(int'(vec_o), exp_vec, cur, "vec_o");
            check(int'(vec_line_o), exp_line, cur, "vec_line_o");
        end
    endtask

    task automatic wr(input int a, input int d);      run_cycle(0, 1, 0, a, 1, d); endtask
    task automatic wr_len(input int a, input int l, input int d); run_cycle(0, 1, 0, a, l, d); endtask
    task automatic rd(input int a);                   run_cycle(0, 0, 1, a, 1, 0); endtask
    task automatic rd_len(input int a, input int l);  run_cycle(0, 0, 1, a, l, 0); endtask
    task automatic ack();                             run_cycle(1, 0, 0, 0, 1, 0); endtask
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) run_cycle(0, 0, 0, 0, 1, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        cur = "R1";
        check(int'(int_o), 0, cur, "int_o after reset");
        check(int'(vec_vld_o), 0, cur, "vec_vld_o after reset");
        rd('h20); rd('h21); rd('hA0); rd('hA1); rd('h4D0); rd('h4D1);

        cur = "R10";
        wr('h20, 'h11); wr('h21, 'h08); wr('h21, 'h04); wr('h21, 'h01);
        wr('hA0, 'h11); wr('hA1, 'h70); wr('hA1, 'h02); wr('hA1, 'h01);
        rd('h21); wr('h21, 'hF0); rd('h21); wr('h21, 'h00);
        wr('hA0, 'h10); wr('hA1, 'h70); wr('hA1, 'h02); wr('hA1, 'h44); rd('hA1); wr('hA1, 'h00);

        cur = "R2";
        lines_r[0] = 1'b1; idle(2);
        cur = "R4"; ack(); idle(1);
        cur = "R9"; wr('h20, 'h20); idle(2);
        cur = "R2"; lines_r[0] = 1'b0; idle(1); lines_r[0] = 1'b1; idle(2); ack(); wr('h20, 'h20);
        lines_r[0] = 1'b0; idle(1);
        wr('h4D1, 'hFF); rd('h4D1); wr('h4D0, 'hFF); rd('h4D0);
        lines_r[9] = 1'b1; idle(2); ack(); idle(2);
        wr('hA0, 'h20); wr('h20, 'h20); idle(2); ack(); wr('hA0, 'h20); wr('h20, 'h20);
        lines_r[9] = 1'b0; idle(3);
        lines_r[3] = 1'b1; idle(2); ack(); idle(1); wr('h20, 'h20); idle(1);
        lines_r[3] = 1'b0; idle(2);
        wr('h4D1, 'h00); wr('h4D0, 'h00); idle(1);

        cur = "R5";
        lines_r[11] = 1'b1; idle(2); ack(); idle(1);
        wr('hA0, 'h20); wr('h20, 'h20); lines_r[11] = 1'b0; idle(2);

        cur = "R6";
        ack(); idle(1); rd('h20);

        cur = "R7";
        lines_r[13] = 1'b1; idle(2); wr('hA1, 'h20); idle(1); ack(); idle(1);
        wr('h20, 'h20); wr('hA1, 'h00); idle(2); ack(); wr('hA0, 'h20); wr('h20, 'h20);
        lines_r[13] = 1'b0; idle(2);

        cur = "R3";
        lines_r[3] = 1'b1; lines_r[5] = 1'b1; idle(2); ack();
        cur = "R9"; wr('h20, 'h63); wr('h20, 'hE3);
        cur = "R3"; lines_r[1] = 1'b1; idle(2); ack(); idle(2);
        wr('h20, 'h20); idle(1); wr('h21, 'h02); idle(2); wr('h21, 'h00); idle(1);
        ack(); wr('h20, 'h20);
        cur = "R9"; wr('h20, 'hC7); lines_r = '0; idle(1);
        lines_r[6] = 1'b1; lines_r[7] = 1'b1; idle(2); ack(); wr('h20, 'hA0); idle(1);
        ack(); wr('h20, 'h20); wr('h20, 'h40); wr('h20, 'hC7); lines_r = '0; idle(2);

        cur = "R12";
        wr('h20, 'h0B); rd('h20); lines_r[4] = 1'b1; idle(2); ack(); rd('h20);
        wr('h20, 'h0A); rd('h20); wr('h20, 'h20); rd('h20);
        wr_len('h21, 2, 'hFF); rd('h21); rd_len('h21, 2);
        wr('h22, 'hFF); rd('h22); rd('h21); wr_len('hA1, 4, 'hFF); rd('hA1);
        lines_r = '0; idle(2);

        cur = "R8";
        wr('h20, 'h11); wr('h21, 'h08); wr('h21, 'h04); wr('h21, 'h03);
        wr('h20, 'h80); lines_r[4] = 1'b1; idle(2); ack();
        wr('h20, 'h0B); rd('h20);
        lines_r[1] = 1'b1; lines_r[6] = 1'b1; idle(2); ack(); idle(1); ack(); idle(1);
        rd('h20); wr('h20, 'h00); lines_r = '0; idle(2);

        cur = "R11";
        wr('h20, 'h11); wr('h21, 'h08); wr('h21, 'h04); wr('h21, 'h11);
        lines_r[12] = 1'b1; idle(2); ack(); idle(1);
        lines_r[9] = 1'b1; idle(3); ack(); idle(1);
        wr('hA0, 'h20); wr('hA0, 'h20); wr('h20, 'h20); lines_r = '0; idle(3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule